// File: doc/BRIEF.md
# Legacy I/O Claim Decoder

This block watches the address phase of each bus transaction and decides whether the block claims it, and on which clock the claim is made. Three fixed legacy I/O windows are recognised: the primary disk-controller window, the secondary disk-controller window and the DMA upper-page window. A hit in a window that is not rejected is a legacy hit. A legacy hit is claimed on a clock chosen by a two-bit speed setting. An I/O address that is not a legacy hit falls to subtractive decode. Subtractive decode claims on the fourth clock, unless a global switch turns it off. Each window has its own reject bit, which moves that window from legacy decode to subtractive decode.

The address phase counts as clock 1. The claim output is a one-cycle pulse during the chosen clock. If another target claims earlier, the pending claim is dropped. A flag that goes with the pulse tells the data path whether a legacy claim follows the hold policy or the retry policy when data is not ready. The speed setting is also returned on a readback port. On that port the reserved code is folded to medium. All settings are sampled in the address phase. There is no data stream in this block, so every pin is a plain control or status signal.

Top module: `legacy_io_claim`

## Requirements
- R1: Speed code 2'b10 (medium) and the reserved code 2'b11 both claim a legacy hit on clock 2, which is the cycle after the address phase.
- R2: Speed code 2'b01 (slow) claims a legacy hit on clock 3.
- R3: Speed code 2'b00 claims a legacy hit on clock 4.
- R4: `speed_rb` returns 2'b10 when the speed setting is 2'b11. For every other code it returns the setting unchanged.
- R5: Addresses 0x1F0–0x1F7 and 0x3F6 form the primary window. When `rej_pri`=1, these addresses are handled by subtractive decode instead.
- R6: Addresses 0x170–0x177 and 0x376 form the secondary window. `rej_sec`=1 moves them to subtractive decode.
- R7: Addresses 0x480–0x48F form the upper-page window. `rej_hpg`=1 moves them to subtractive decode.
- R8: An I/O address that is not a legacy hit is claimed on clock 4 when `sub_off`=0. It is never claimed when `sub_off`=1. A legacy hit is claimed whatever `sub_off` holds.
- R9: A transaction with `is_io`=0 (memory) is never claimed.
- R10: If `other_claim` is high on any clock from the address phase up to the clock before the claim clock, there is no claim. If `other_claim` is high only on the claim clock itself, the claim still happens.
- R11: `claim` lasts exactly one cycle for each transaction.
- R12: `claim_hold` equals `pol_hold` for a legacy claim. It is 0 for a subtractive claim, and it is 0 whenever `claim` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | High for the one address-phase cycle of a transaction |
| is_io | input | 1 | 1 when the command is in I/O space, 0 for memory |
| addr | input | 16 | I/O address, sampled while addr_valid is high |
| other_claim | input | 1 | Another target has claimed the current transaction |
| cfg_speed | input | 2 | Legacy claim speed: 00 fourth, 01 third, 10/11 second clock |
| rej_pri | input | 1 | Move the primary window to subtractive decode |
| rej_sec | input | 1 | Move the secondary window to subtractive decode |
| rej_hpg | input | 1 | Move the upper-page window to subtractive decode |
| sub_off | input | 1 | Disable subtractive claiming |
| pol_hold | input | 1 | Legacy not-ready policy: 0 retry, 1 hold |
| speed_rb | output | 2 | Readback of the speed setting, reserved code folded to 10 |
| claim | output | 1 | One-cycle claim pulse |
| claim_hold | output | 1 | With claim: the hold policy applies |

## Verification
The assertions assume that `addr_valid` is high for a single cycle. They also assume that a new address phase starts only once the previous transaction has claimed or been dropped. For that reason, the single-pulse and cancel checks stand down in any cycle where `addr_valid` is high. Every bench transaction holds `addr_valid` for one cycle and then leaves at least five idle clocks. During those clocks `other_claim` is driven, on the chosen clock, only inside the transaction window. The configuration pins are changed only between transactions, so the settings taken at the address phase match the ones the bench expects.

// File: rtl/legacy_io_claim_pkg.sv
package legacy_io_claim_pkg;
  localparam int IO_AW   = 16;
  localparam int CLK_W   = 3;
  localparam int N_WIN   = 3;

  typedef enum logic [1:0] {
    SPD_SUBTR = 2'b00,
    SPD_SLOW  = 2'b01,
    SPD_MED   = 2'b10,
    SPD_RSVD  = 2'b11
  } speed_e;

  // window table: index 0 primary, 1 secondary, 2 upper page
  localparam logic [IO_AW-1:0] WIN_BASE [N_WIN] = '{16'h01F0, 16'h0170, 16'h0480};
  localparam int               WIN_SPAN [N_WIN] = '{8, 8, 16};
  localparam bit               WIN_HAS_ALT [N_WIN] = '{1'b1, 1'b1, 1'b0};
  localparam logic [IO_AW-1:0] WIN_ALT  [N_WIN] = '{16'h03F6, 16'h0376, 16'h0000};

  localparam logic [CLK_W-1:0] SUBTR_CLK = CLK_W'(4);

  function automatic logic [CLK_W-1:0] legacy_clock(input logic [1:0] spd);
    case (spd)
      SPD_SUBTR: legacy_clock = CLK_W'(4);
      SPD_SLOW:  legacy_clock = CLK_W'(3);
      default:   legacy_clock = CLK_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/io_window_match.sv
module io_window_match #(
  parameter int                AW      = 16,
  parameter logic [AW-1:0]     BASE    = '0,
  parameter int                SPAN    = 8,
  parameter bit                HAS_ALT = 1'b0,
  parameter logic [AW-1:0]     ALT     = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW:0] LIMIT = {1'b0, BASE} + (AW+1)'(SPAN);

  logic in_span;
  logic alt_hit;

  always_comb begin
    in_span = ({1'b0, addr} >= {1'b0, BASE}) && ({1'b0, addr} < LIMIT);
  end

  generate
    if (HAS_ALT) begin : g_alt
      assign alt_hit = (addr == ALT);
    end else begin : g_noalt
      assign alt_hit = 1'b0;
    end
  endgenerate

  assign hit = in_span | alt_hit;
endmodule

// File: rtl/claim_timer.sv
module claim_timer
  import legacy_io_claim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             arm,
  input  logic [CLK_W-1:0] tgt,
  input  logic             legacy,
  input  logic             hold,
  input  logic             other_claim,
  output logic             claim,
  output logic             claim_hold
);
  logic             active_q;
  logic [CLK_W-1:0] cnt_q;
  logic [CLK_W-1:0] tgt_q;
  logic             leg_q;
  logic             hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      tgt_q    <= '0;
      leg_q    <= 1'b0;
      hold_q   <= 1'b0;
    end else if (start) begin
      active_q <= arm && !other_claim;
      cnt_q    <= CLK_W'(2);
      tgt_q    <= tgt;
      leg_q    <= legacy;
      hold_q   <= hold;
    end else if (active_q) begin
      if (other_claim || cnt_q == tgt_q) active_q <= 1'b0;
      cnt_q <= cnt_q + CLK_W'(1);
    end
  end

  assign claim      = active_q && (cnt_q == tgt_q);
  assign claim_hold = claim && leg_q && hold_q;

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !start) |=> !claim);

  assert_cancel_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (other_claim && !start) |=> !claim);
endmodule

// File: rtl/legacy_io_claim.sv
module legacy_io_claim
  import legacy_io_claim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_valid,
  input  logic        is_io,
  input  logic [15:0] addr,
  input  logic        other_claim,
  input  logic [1:0]  cfg_speed,
  input  logic        rej_pri,
  input  logic        rej_sec,
  input  logic        rej_hpg,
  input  logic        sub_off,
  input  logic        pol_hold,
  output logic [1:0]  speed_rb,
  output logic        claim,
  output logic        claim_hold
);
  logic [N_WIN-1:0] win_hit;
  logic [N_WIN-1:0] win_rej;
  logic             legacy_hit;
  logic             arm;
  logic [CLK_W-1:0] tgt;

  assign win_rej = {rej_hpg, rej_sec, rej_pri};

  genvar gi;
  generate
    for (gi = 0; gi < N_WIN; gi++) begin : g_win
      io_window_match #(
        .AW     (IO_AW),
        .BASE   (WIN_BASE[gi]),
        .SPAN   (WIN_SPAN[gi]),
        .HAS_ALT(WIN_HAS_ALT[gi]),
        .ALT    (WIN_ALT[gi])
      ) u_match (
        .addr(addr),
        .hit (win_hit[gi])
      );
    end
  endgenerate

  always_comb begin
    legacy_hit = is_io && |(win_hit & ~win_rej);
    arm        = is_io && (legacy_hit || !sub_off);
    tgt        = legacy_hit ? legacy_clock(cfg_speed) : SUBTR_CLK;
    speed_rb   = (cfg_speed == SPD_RSVD) ? SPD_MED : cfg_speed;
  end

  claim_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (addr_valid),
    .arm        (arm),
    .tgt        (tgt),
    .legacy     (legacy_hit),
    .hold       (pol_hold),
    .other_claim(other_claim),
    .claim      (claim),
    .claim_hold (claim_hold)
  );

  assert_memory_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !is_io) |=> !claim);

  assert_suboff_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && is_io && sub_off && (win_hit == '0)) |=> !claim);

  assert_medium_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && is_io && win_hit[0] && !rej_pri && cfg_speed[1] && !other_claim) |=> claim);

  assert_subtr_not_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && is_io && (win_hit == '0)) |=> !claim);

  assert_hold_with_claim_R12: assert property (@(posedge clk) disable iff (!rst_n)
    claim_hold |-> claim);
endmodule

// File: tb/tb_legacy_io_claim.sv
module tb_legacy_io_claim;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0;
  logic        is_io = 1'b0;
  logic [15:0] addr = '0;
  logic        other_claim = 1'b0;
  logic [1:0]  cfg_speed = 2'b10;
  logic        rej_pri = 1'b0, rej_sec = 1'b0, rej_hpg = 1'b0;
  logic        sub_off = 1'b0, pol_hold = 1'b0;
  logic [1:0]  speed_rb;
  logic        claim, claim_hold;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  legacy_io_claim dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .is_io(is_io), .addr(addr),
    .other_claim(other_claim), .cfg_speed(cfg_speed), .rej_pri(rej_pri),
    .rej_sec(rej_sec), .rej_hpg(rej_hpg), .sub_off(sub_off), .pol_hold(pol_hold),
    .speed_rb(speed_rb), .claim(claim), .claim_hold(claim_hold)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one transaction; oc = clock on which other_claim is driven (0 = never)
  task automatic txn(input logic [15:0] a, input logic io, input int oc,
                     output int clk_no, output int pulses, output int hold_seen);
    clk_no = 0; pulses = 0; hold_seen = 0;
    @(negedge clk);
    addr_valid = 1'b1; addr = a; is_io = io; other_claim = (oc == 1);
    @(posedge clk);
    for (int k = 2; k <= 7; k++) begin
      @(negedge clk);
      addr_valid = 1'b0;
      other_claim = (oc == k);
      if (claim) begin
        pulses++;
        if (clk_no == 0) clk_no = k;
        if (claim_hold) hold_seen = 1;
      end else if (claim_hold) hold_seen = 2;
      @(posedge clk);
    end
    @(negedge clk);
    other_claim = 1'b0;
  endtask

  task automatic expect_clk(input string req, input logic [15:0] a, input logic io,
                            input int oc, input int exp_clk);
    int c, p, h;
    txn(a, io, oc, c, p, h);
    check(req, c, exp_clk);
    check(req, p, (exp_clk == 0) ? 0 : 1);
  endtask

  task automatic t_reset();
    check("R11 reset claim", claim, 0);
    check("R12 reset hold", claim_hold, 0);
  endtask

  task automatic t_speed();
    cfg_speed = 2'b10; #1; check("R4 rb 10", speed_rb, 2);
    expect_clk("R1 medium", 16'h01F0, 1'b1, 0, 2);
    cfg_speed = 2'b11; #1; check("R4 rb 11", speed_rb, 2);
    expect_clk("R1 reserved", 16'h01F0, 1'b1, 0, 2);
    cfg_speed = 2'b01; #1; check("R4 rb 01", speed_rb, 1);
    expect_clk("R2 slow", 16'h01F4, 1'b1, 0, 3);
    cfg_speed = 2'b00; #1; check("R4 rb 00", speed_rb, 0);
    expect_clk("R3 fourth", 16'h0172, 1'b1, 0, 4);
    cfg_speed = 2'b10;
  endtask

  task automatic t_windows();
    expect_clk("R5 1F7", 16'h01F7, 1'b1, 0, 2);
    expect_clk("R5 3F6", 16'h03F6, 1'b1, 0, 2);
    expect_clk("R5 1F8 outside", 16'h01F8, 1'b1, 0, 4);
    expect_clk("R5 1EF outside", 16'h01EF, 1'b1, 0, 4);
    expect_clk("R6 170", 16'h0170, 1'b1, 0, 2);
    expect_clk("R6 177", 16'h0177, 1'b1, 0, 2);
    expect_clk("R6 376", 16'h0376, 1'b1, 0, 2);
    expect_clk("R6 16F outside", 16'h016F, 1'b1, 0, 4);
    expect_clk("R7 480", 16'h0480, 1'b1, 0, 2);
    expect_clk("R7 48F", 16'h048F, 1'b1, 0, 2);
    expect_clk("R7 490 outside", 16'h0490, 1'b1, 0, 4);
    expect_clk("R7 47F outside", 16'h047F, 1'b1, 0, 4);
  endtask

  task automatic t_reject();
    rej_pri = 1'b1;
    expect_clk("R5 reject 1F3", 16'h01F3, 1'b1, 0, 4);
    expect_clk("R5 reject 3F6", 16'h03F6, 1'b1, 0, 4);
    expect_clk("R6 kept with pri reject", 16'h0170, 1'b1, 0, 2);
    sub_off = 1'b1;
    expect_clk("R5 reject and sub off", 16'h01F3, 1'b1, 0, 0);
    sub_off = 1'b0; rej_pri = 1'b0;
    rej_sec = 1'b1;
    expect_clk("R6 reject 376", 16'h0376, 1'b1, 0, 4);
    rej_sec = 1'b0; rej_hpg = 1'b1;
    expect_clk("R7 reject 485", 16'h0485, 1'b1, 0, 4);
    rej_hpg = 1'b0;
  endtask

  task automatic t_suboff();
    expect_clk("R8 subtractive on", 16'h0300, 1'b1, 0, 4);
    sub_off = 1'b1;
    expect_clk("R8 subtractive off", 16'h0300, 1'b1, 0, 0);
    expect_clk("R8 legacy with sub off", 16'h01F0, 1'b1, 0, 2);
    sub_off = 1'b0;
  endtask

  task automatic t_memory();
    expect_clk("R9 memory at legacy addr", 16'h01F0, 1'b0, 0, 0);
    expect_clk("R9 memory elsewhere", 16'h0300, 1'b0, 0, 0);
  endtask

  task automatic t_other();
    cfg_speed = 2'b00;
    expect_clk("R10 other on clock 3", 16'h01F0, 1'b1, 3, 0);
    expect_clk("R10 other on clock 1", 16'h01F0, 1'b1, 1, 0);
    expect_clk("R10 other on claim clock", 16'h01F0, 1'b1, 4, 4);
    cfg_speed = 2'b10;
    expect_clk("R10 other before subtractive", 16'h0300, 1'b1, 2, 0);
    expect_clk("R10 other after medium claim", 16'h01F0, 1'b1, 3, 2);
  endtask

  task automatic t_hold();
    int c, p, h;
    pol_hold = 1'b1;
    txn(16'h01F0, 1'b1, 0, c, p, h);
    check("R12 legacy hold", h, 1);
    check("R11 legacy pulse count", p, 1);
    txn(16'h0300, 1'b1, 0, c, p, h);
    check("R12 subtractive no hold", h, 0);
    check("R11 subtractive pulse count", p, 1);
    pol_hold = 1'b0;
    txn(16'h0480, 1'b1, 0, c, p, h);
    check("R12 legacy retry", h, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_speed();
    t_windows();
    t_reject();
    t_suboff();
    t_memory();
    t_other();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule